// File: doc/BRIEF.md
# Slot-Timed Nibble Processing Unit

This block is a small 4-bit processing unit that takes everything it needs from one shared 4-bit input bus. A free-running 3-bit counter wraps every eight clocks and sets all of the timing. The opcode is sampled in one fixed slot and the two operands in two later slots. The computed value is written to a result register in the final slot. No handshake is used: whatever drives the bus must present each item during its slot.

The unit performs seven operations: add, subtract, unsigned magnitude compare, XOR, AND, OR and one's-complement NOT. The result register drives the output bits. A valid strobe is high during count 0, the first count of each cycle, which is when a freshly written result first appears at the output. Bus bit 3 is the most significant bit for opcodes and for operands alike.

Top module: `nib_cpu`

## Requirements
- R1: The valid strobe `data_vld` is high while the slot counter is at 0, and low at the other seven counts. After reset it is therefore high once every 8 clocks, starting with the first clock after reset is released.
- R2: The bus is sampled only at the clock edge that ends count 1 (opcode), count 3 (operand A) and count 4 (operand B). Bus values at counts 0, 2, 5, 6 and 7 have no effect on the result.
- R3: The result register is written only at the edge that ends count 7. Its new value is visible during count 0 and is held unchanged until the next write.
- R4: With `rst_n` low at a clock edge, the slot counter and all registers clear to 0. As a result, `res_out` is 0 and the first count after release is count 0.
- R5: Opcode 4'h4 (add) gives (A + B) mod 16.
- R6: Opcode 4'h1 (subtract) gives (A − B) mod 16, in two's complement.
- R7: Opcode 4'h2 (compare) treats A and B as unsigned and gives 4'b0001 when A > B, 4'b0010 when A < B and 4'b0100 when A = B.
- R8: Opcode 4'h6 gives A XOR B, opcode 4'h7 gives A AND B and opcode 4'hA gives A OR B.
- R9: Opcode 4'hE gives the bitwise inverse of A. Operand B has no effect on this result.
- R10: Every other opcode value writes 4'h0 to the result register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, free-running |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 4 | Shared opcode/operand bus, bit 3 is the MSB |
| res_out | output | 4 | Result register contents |
| data_vld | output | 1 | High during count 0, when the result is valid |

## Verification
The properties assume that reset is held low for at least one clock edge before operation, and that the clock then runs without pause. The cycle-spacing check counts from the count-0 strobe that follows reset, so it relies on the counter never being reloaded mid-run. The bench sets up its phase once, at reset release, and after that drives every bus value on the falling edge inside its own slot. This keeps each sampled value stable around the rising edge. To exercise the slots that must be ignored, the bench puts deliberately different values on the bus at counts 0, 2, 5, 6 and 7.

// File: rtl/nib_pkg.sv
// Shared definitions for the nibble processing unit: opcode encodings,
// slot indices of the modulo-8 schedule and compare result codes.
// Assumes an opcode width of 4 bits and a 3-bit slot counter.
package nib_pkg;

    localparam int unsigned OPW = 4;
    localparam int unsigned SLW = 3;

    typedef enum logic [OPW-1:0] {
        OP_SUB = 4'h1,
        OP_CMP = 4'h2,
        OP_ADD = 4'h4,
        OP_XOR = 4'h6,
        OP_AND = 4'h7,
        OP_OR  = 4'hA,
        OP_NOT = 4'hE
    } op_e;

    localparam logic [SLW-1:0] SLOT_VLD = 3'd0;
    localparam logic [SLW-1:0] SLOT_OP  = 3'd1;
    localparam logic [SLW-1:0] SLOT_A   = 3'd3;
    localparam logic [SLW-1:0] SLOT_B   = 3'd4;
    localparam logic [SLW-1:0] SLOT_WR  = 3'd7;

    localparam int unsigned CMP_GT_BIT = 0;
    localparam int unsigned CMP_LT_BIT = 1;
    localparam int unsigned CMP_EQ_BIT = 2;

endpackage

// File: rtl/nib_slot_ctr.sv
// Free-running slot counter. Advances once per clock and wraps through
// all 2**CW states. Assumes a synchronous active-low reset that clears it.
module nib_slot_ctr #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_q;

    // Advance the schedule position by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/nib_alu.sv
// Combinational operation unit. Decodes the opcode and produces a DW-bit
// result from operands A and B. Undefined opcodes give zero. Assumes DW >= 3
// so that the three compare code bits fit.
module nib_alu
    import nib_pkg::*;
#(
    parameter int unsigned DW = 4
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  y
);

    logic [DW-1:0] cmp_code;

    // Build the one-hot magnitude compare code.
    always_comb begin
        cmp_code = '0;
        if (a > b)      cmp_code[CMP_GT_BIT] = 1'b1;
        else if (a < b) cmp_code[CMP_LT_BIT] = 1'b1;
        else            cmp_code[CMP_EQ_BIT] = 1'b1;
    end

    // Select the operation result for the decoded opcode.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_CMP:  y = cmp_code;
            OP_XOR:  y = a ^ b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOT:  y = ~a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/nib_cpu.sv
// Slot-timed nibble processing unit. Captures opcode, operand A and operand
// B from a shared bus in fixed counter slots, writes the result in the last
// slot and flags it valid in slot 0. Assumes that the bus source keeps to
// the slot schedule and that reset is synchronous and active low.
module nib_cpu
    import nib_pkg::*;
#(
    parameter int unsigned DW = 4,
    parameter int unsigned CW = SLW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] res_out,
    output logic          data_vld
);

    logic [CW-1:0]  cnt_q;
    logic [OPW-1:0] op_q;
    logic [DW-1:0]  a_q;
    logic [DW-1:0]  b_q;
    logic [DW-1:0]  res_q;
    logic [DW-1:0]  alu_y;

    nib_slot_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_q)
    );

    // Capture opcode and operands from the bus in their own slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
        end else begin
            if (cnt_q == CW'(SLOT_OP)) op_q <= bus_in[OPW-1:0];
            if (cnt_q == CW'(SLOT_A))  a_q  <= bus_in;
            if (cnt_q == CW'(SLOT_B))  b_q  <= bus_in;
        end
    end

    nib_alu #(.DW(DW)) u_alu (
        .op (op_q),
        .a  (a_q),
        .b  (b_q),
        .y  (alu_y)
    );

    // Load the result register in the write slot only.
    always_ff @(posedge clk) begin
        if (!rst_n)                     res_q <= '0;
        else if (cnt_q == CW'(SLOT_WR)) res_q <= alu_y;
    end

    assign res_out  = res_q;
    assign data_vld = (cnt_q == CW'(SLOT_VLD));

endmodule

// File: rtl/nib_cpu_chk.sv
// Property checker for nib_cpu, bound to every instance. Assumes reset is
// held low for at least one edge and the clock then runs continuously.
module nib_cpu_chk
    import nib_pkg::*;
#(
    parameter int unsigned DW = 4,
    parameter int unsigned CW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           data_vld,
    input logic [DW-1:0]  res_out,
    input logic [CW-1:0]  cnt,
    input logic [OPW-1:0] op,
    input logic [DW-1:0]  a
);

    localparam int unsigned PERIOD = 1 << CW;

    logic [CW+1:0] gap_q;
    logic          op_known;

    // Count clocks since the last valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap_q <= '0;
        else if (data_vld) gap_q <= (CW+2)'(1);
        else               gap_q <= gap_q + 1'b1;
    end

    // Flag opcodes that have a defined operation.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_XOR,
            OP_AND, OP_OR, OP_NOT: op_known = 1'b1;
            default:               op_known = 1'b0;
        endcase
    end

    p_vld_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |=> !data_vld);

    p_vld_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == (CW+2)'(PERIOD)) |-> data_vld);

    p_vld_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && gap_q != '0) |-> (gap_q == (CW+2)'(PERIOD)));

    p_res_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CW'(SLOT_VLD)) |-> $stable(res_out));

    p_not_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && op == OP_NOT && gap_q != '0) |-> (res_out == ~a));

    p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !op_known) |-> (res_out == '0));

endmodule

bind nib_cpu nib_cpu_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_vld (data_vld),
    .res_out  (res_out),
    .cnt      (cnt_q),
    .op       (op_q),
    .a        (a_q)
);

// File: tb/tb_nib_cpu.sv
// Directed bench for nib_cpu. Each task drives one full 8-count cycle and
// checks its own results at fixed slots, sampling on the falling edge.
module tb_nib_cpu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_in = 4'h0;
    logic [3:0] res_out;
    logic       data_vld;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [3:0]  last_res = 4'h0;
    bit          done = 1'b0;

    nib_cpu dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_in   (bus_in),
        .res_out  (res_out),
        .data_vld (data_vld)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a count-0 falling edge; ends at the next count-0 falling edge.
    task automatic run_op(input string req, input logic [3:0] op, input logic [3:0] a,
                          input logic [3:0] b, input logic [3:0] junk,
                          input logic [3:0] exp);
        bus_in = junk;                                    // count 0, ignored (R2)
        @(negedge clk); bus_in = op;                      // count 1
        check("R1 strobe low at count 1", {3'b0, data_vld}, 4'h0);
        @(negedge clk); bus_in = ~junk;                   // count 2, ignored (R2)
        @(negedge clk); bus_in = a;                       // count 3
        @(negedge clk); bus_in = b;                       // count 4
        check("R3 result held before write", res_out, last_res);
        @(negedge clk); bus_in = junk ^ 4'h5;             // count 5, ignored (R2)
        @(negedge clk); bus_in = junk ^ 4'hA;             // count 6, ignored (R2)
        @(negedge clk); bus_in = ~op;                     // count 7, ignored (R2)
        check("R1 strobe low at count 7", {3'b0, data_vld}, 4'h0);
        @(negedge clk);                                   // count 0
        check(req, res_out, exp);
        check("R1 strobe high at count 0", {3'b0, data_vld}, 4'h1);
        last_res = exp;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        bus_in = 4'hF;
        repeat (3) @(negedge clk);
        check("R4 result cleared in reset", res_out, 4'h0);
        rst_n = 1'b1;
        check("R4 result zero at release", res_out, 4'h0);
        check("R4 count 0 first after release", {3'b0, data_vld}, 4'h1);
        last_res = 4'h0;
    endtask

    task automatic t_arith();
        run_op("R5 add 3+4", 4'h4, 4'h3, 4'h4, 4'h9, 4'h7);
        run_op("R5 add wraps 9+8", 4'h4, 4'h9, 4'h8, 4'h2, 4'h1);
        run_op("R6 sub 9-2", 4'h1, 4'h9, 4'h2, 4'hC, 4'h7);
        run_op("R6 sub borrow 3-5", 4'h1, 4'h3, 4'h5, 4'h0, 4'hE);
    endtask

    task automatic t_compare();
        run_op("R7 cmp 5>3", 4'h2, 4'h5, 4'h3, 4'hF, 4'h1);
        run_op("R7 cmp 3<5", 4'h2, 4'h3, 4'h5, 4'h7, 4'h2);
        run_op("R7 cmp 7=7", 4'h2, 4'h7, 4'h7, 4'h1, 4'h4);
        run_op("R7 cmp unsigned F>0", 4'h2, 4'hF, 4'h0, 4'h8, 4'h1);
    endtask

    task automatic t_logic();
        run_op("R8 xor", 4'h6, 4'hC, 4'hA, 4'h3, 4'h6);
        run_op("R8 and", 4'h7, 4'hC, 4'hA, 4'h3, 4'h8);
        run_op("R8 or",  4'hA, 4'hC, 4'hA, 4'h0, 4'hE);
        run_op("R9 not A=5", 4'hE, 4'h5, 4'h0, 4'hB, 4'hA);
        run_op("R9 not B ignored", 4'hE, 4'h5, 4'hF, 4'h6, 4'hA);
        run_op("R9 not A=0", 4'hE, 4'h0, 4'h3, 4'h9, 4'hF);
    endtask

    task automatic t_undefined();
        run_op("R10 opcode F", 4'hF, 4'h6, 4'h3, 4'h2, 4'h0);
        run_op("R5 add before zero op", 4'h4, 4'h6, 4'h3, 4'hD, 4'h9);
        run_op("R10 opcode 0", 4'h0, 4'hA, 4'h5, 4'h4, 4'h0);
        run_op("R10 opcode 3", 4'h3, 4'hA, 4'h5, 4'hE, 4'h0);
    endtask

    task automatic t_ignored_slots();
        // Junk at counts 0,2,5,6,7 differs from the real items (R2).
        run_op("R2 junk slots ignored (or)", 4'hA, 4'h1, 4'h2, 4'hC, 4'h3);
        run_op("R2 junk slots ignored (sub)", 4'h1, 4'h8, 4'h1, 4'h7, 4'h7);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_compare();
        t_logic();
        t_undefined();
        t_ignored_slots();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule